// File: doc/BRIEF.md
# Disk Power Mode Controller

This block follows the power condition of a disk drive as decoded host commands arrive. It holds one of seven states: SpinUp, Active, Idle, IdleNoSpin, SpinDown, Standby and Sleep. Each command opcode is sorted into a class: idle, idle-now, standby, standby-now, sleep, power query, or media access. The class and the current state then decide whether the spindle is requested, whether a spin-down starts, whether completion is signalled and whether a media command may run. The motor itself lies outside the block. It reports back through two inputs. `spin_ready` means the spindle is at speed, and `spin_stopped` means it has come to rest.

Transitions:
- Active or Idle goes to Idle on an idle command, to Active on media access, and to SpinDown on standby while the spindle turns.
- Active or Idle goes straight to Standby on standby when `spin_stopped` is already high. This is the skip.
- Standby, SpinDown and IdleNoSpin go to IdleNoSpin on an idle command.
- Standby, SpinDown and IdleNoSpin go to SpinUp on media access.
- SpinDown goes to Standby once `spin_stopped` is high.
- Any accepting state goes to Sleep on a sleep command.
- SpinUp goes to Active when `spin_ready` arrives with a media command pending, and to Idle otherwise.
- A `host_rst` pulse sends any state to SpinUp. It is the only way out of Sleep.

Completion of standby is signalled as soon as the spin-down begins. The host does not wait for the media to stop. A power query returns the code for the current state without changing it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Opcodes are decoded as follows: idle E3h/97h, idle-now E1h/95h, standby E2h/96h, standby-now E0h/94h, sleep E6h/99h, query E5h/98h. Any other opcode is media access. The 9xh forms are honoured only while ACCEPT_OLD_CODES=1, which is the default. With ACCEPT_OLD_CODES=0 they count as media access.
- R2: After rst_n the outputs read as follows: spin_en=1, busy=1, if_active=1, cmd_done=0, exec_go=0, spin_dn=0 and pwr_code=00h.
- R3: A query gives a one-cycle cmd_done pulse. It loads pwr_code with 00h in Standby or SpinDown and with FFh in Active, Idle or IdleNoSpin. The state does not change.
- R4: An idle command gives cmd_done. From Active or Idle it leads to Idle with the spindle still requested. From Standby, SpinDown or IdleNoSpin it leads to IdleNoSpin with spin_en=0.
- R5: A standby command in Active or Idle while spin_stopped=0 leads to SpinDown. In the same cycle spin_en drops, spin_dn pulses and cmd_done pulses, all before the spindle stops. SpinDown moves on to Standby when spin_stopped=1.
- R6: A standby command gives cmd_done without any spin_dn pulse in three cases: the spindle is not requested, spin_stopped=1 is already seen, or a spin-down is already in progress. The drive then ends in Standby, or stays in SpinDown if it was spinning down.
- R7: In Standby and SpinDown, if_active stays 1 and commands are accepted.
- R8: A sleep command gives cmd_done with spin_en=0 and if_active=0. From then on, every command yields no cmd_done, no exec_go and no change of state until host_rst.
- R9: host_rst takes priority over any command. From any state it leads to SpinUp with spin_en=1, busy=1 and if_active=1. The next spin_ready leads to Idle without exec_go.
- R10: Media access in Active or Idle gives exec_go one cycle later and leads to Active. In Standby, SpinDown or IdleNoSpin it leads to SpinUp with spin_en=1 and busy=1. exec_go then follows the cycle after spin_ready is sampled.
- R11: While busy=1 (in SpinUp), commands are ignored and give no cmd_done.
- R12: All outputs are registered. A command sampled at a rising edge shows its effect right after that edge, and cmd_done lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| host_rst | input | 1 | Drive reset pulse; leaves any state, including Sleep |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command opcode |
| spin_ready | input | 1 | Spindle at speed |
| spin_stopped | input | 1 | Spindle at rest |
| spin_en | output | 1 | Spindle run request |
| spin_dn | output | 1 | One-cycle pulse when a spin-down sequence starts |
| if_active | output | 1 | Host interface accepting commands |
| busy | output | 1 | Waiting for spin-up; commands ignored |
| cmd_done | output | 1 | Completion/interrupt pulse for power commands |
| exec_go | output | 1 | Pulse permitting a media command to run |
| pwr_code | output | 8 | Power mode code captured by the last query |

## Verification
A wrong state shows up at the ports within one cycle of the next command, and usually of the very next query. pwr_code separates the stopped states from the spinning ones. spin_en separates Idle from IdleNoSpin, if_active exposes Sleep, and busy exposes SpinUp. A missing or extra spin_dn or exec_go pulse shows a wrong transition choice in the cycle right after the command. Commands given in Sleep or SpinUp are followed by a query so that a state which leaked is caught at once.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int PM_OPC_W = 8;

    localparam logic [PM_OPC_W-1:0] PM_CODE_STOPPED  = '0;
    localparam logic [PM_OPC_W-1:0] PM_CODE_SPINNING = '1;

    typedef enum logic [2:0] {
        PM_SPINUP,
        PM_ACTIVE,
        PM_IDLE,
        PM_IDLE_NOSPIN,
        PM_SPINDOWN,
        PM_STANDBY,
        PM_SLEEP
    } pm_state_t;

    typedef enum logic [2:0] {
        CC_NONE,
        CC_IDLE,
        CC_IDLE_NOW,
        CC_STBY,
        CC_STBY_NOW,
        CC_SLEEP,
        CC_QUERY,
        CC_MEDIA
    } cmd_cls_t;

    function automatic cmd_cls_t cls_current(input logic [PM_OPC_W-1:0] op);
        case (op)
            8'hE3:   return CC_IDLE;
            8'hE1:   return CC_IDLE_NOW;
            8'hE2:   return CC_STBY;
            8'hE0:   return CC_STBY_NOW;
            8'hE6:   return CC_SLEEP;
            8'hE5:   return CC_QUERY;
            default: return CC_MEDIA;
        endcase
    endfunction

    function automatic cmd_cls_t cls_legacy(input logic [PM_OPC_W-1:0] op);
        case (op)
            8'h97:   return CC_IDLE;
            8'h95:   return CC_IDLE_NOW;
            8'h96:   return CC_STBY;
            8'h94:   return CC_STBY_NOW;
            8'h99:   return CC_SLEEP;
            8'h98:   return CC_QUERY;
            default: return CC_MEDIA;
        endcase
    endfunction

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
    import pwr_pkg::*;
#(
    parameter bit ACCEPT_OLD_CODES = 1'b1
) (
    input  logic                cmd_valid,
    input  logic [PM_OPC_W-1:0] cmd_code,
    output cmd_cls_t            cmd_cls
);

    cmd_cls_t cur_cls;
    cmd_cls_t sel_cls;

    assign cur_cls = cls_current(cmd_code);

    generate
        if (ACCEPT_OLD_CODES) begin : g_both_sets
            cmd_cls_t old_cls;
            assign old_cls = cls_legacy(cmd_code);
            // A recognised legacy opcode wins; otherwise the current set decides.
            assign sel_cls = (old_cls != CC_MEDIA) ? old_cls : cur_cls;
        end else begin : g_current_only
            assign sel_cls = cur_cls;
        end
    endgenerate

    assign cmd_cls = cmd_valid ? sel_cls : CC_NONE;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rst,
    input  cmd_cls_t            cmd_cls,
    input  logic                spin_ready,
    input  logic                spin_stopped,
    output pm_state_t           nxt_state,
    output logic                ev_done,
    output logic                ev_exec,
    output logic                ev_spindn,
    output logic                ev_query,
    output logic [PM_OPC_W-1:0] query_code
);

    pm_state_t st;
    logic      pend_media;
    logic      pend_nxt;
    logic      spinning;

    assign spinning = (st == PM_ACTIVE) || (st == PM_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= PM_SPINUP;
            pend_media <= 1'b0;
        end else begin
            st         <= nxt_state;
            pend_media <= pend_nxt;
        end
    end

    // Next state and event decisions
    always_comb begin
        nxt_state  = st;
        pend_nxt   = pend_media;
        ev_done    = 1'b0;
        ev_exec    = 1'b0;
        ev_spindn  = 1'b0;
        ev_query   = 1'b0;
        query_code = PM_CODE_SPINNING;
        if (host_rst) begin
            nxt_state = PM_SPINUP;
            pend_nxt  = 1'b0;
        end else begin
            unique case (st)
                PM_SPINUP: begin
                    if (spin_ready) begin
                        nxt_state = pend_media ? PM_ACTIVE : PM_IDLE;
                        ev_exec   = pend_media;
                        pend_nxt  = 1'b0;
                    end
                end
                PM_SLEEP: begin
                    nxt_state = PM_SLEEP;
                end
                default: begin
                    unique case (cmd_cls)
                        CC_NONE: begin
                        end
                        CC_IDLE, CC_IDLE_NOW: begin
                            ev_done   = 1'b1;
                            nxt_state = spinning ? PM_IDLE : PM_IDLE_NOSPIN;
                        end
                        CC_STBY, CC_STBY_NOW: begin
                            ev_done = 1'b1;
                            if (spinning && !spin_stopped) begin
                                nxt_state = PM_SPINDOWN;
                                ev_spindn = 1'b1;
                            end else if (st == PM_SPINDOWN) begin
                                nxt_state = PM_SPINDOWN;
                            end else begin
                                nxt_state = PM_STANDBY;
                            end
                        end
                        CC_SLEEP: begin
                            ev_done   = 1'b1;
                            nxt_state = PM_SLEEP;
                        end
                        CC_QUERY: begin
                            ev_done    = 1'b1;
                            ev_query   = 1'b1;
                            query_code = ((st == PM_SPINDOWN) || (st == PM_STANDBY))
                                         ? PM_CODE_STOPPED : PM_CODE_SPINNING;
                        end
                        CC_MEDIA: begin
                            if (spinning) begin
                                nxt_state = PM_ACTIVE;
                                ev_exec   = 1'b1;
                            end else begin
                                nxt_state = PM_SPINUP;
                                pend_nxt  = 1'b1;
                            end
                        end
                    endcase
                end
            endcase
            if ((st == PM_SPINDOWN) && (nxt_state == PM_SPINDOWN) && spin_stopped)
                nxt_state = PM_STANDBY;
        end
    end

    AST_SLEEP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_SLEEP && !host_rst) |=> (st == PM_SLEEP)); // R8

    AST_RESET_TO_SPINUP: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> (st == PM_SPINUP)); // R9

    AST_QUERY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cls == CC_QUERY && !host_rst &&
         (st == PM_ACTIVE || st == PM_IDLE || st == PM_IDLE_NOSPIN || st == PM_STANDBY))
        |=> (st == $past(st))); // R3

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PM_SPINUP) |-> !ev_done); // R11

endmodule

// File: rtl/pwr_out_stage.sv
module pwr_out_stage
    import pwr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  pm_state_t           nxt_state,
    input  logic                ev_done,
    input  logic                ev_exec,
    input  logic                ev_spindn,
    input  logic                ev_query,
    input  logic [PM_OPC_W-1:0] query_code,
    output logic                spin_en,
    output logic                spin_dn,
    output logic                if_active,
    output logic                busy,
    output logic                cmd_done,
    output logic                exec_go,
    output logic [PM_OPC_W-1:0] pwr_code
);

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spin_en   <= 1'b1;
            spin_dn   <= 1'b0;
            if_active <= 1'b1;
            busy      <= 1'b1;
            cmd_done  <= 1'b0;
            exec_go   <= 1'b0;
            pwr_code  <= PM_CODE_STOPPED;
        end else begin
            spin_en   <= (nxt_state == PM_ACTIVE) || (nxt_state == PM_IDLE) ||
                         (nxt_state == PM_SPINUP);
            spin_dn   <= ev_spindn;
            if_active <= (nxt_state != PM_SLEEP);
            busy      <= (nxt_state == PM_SPINUP);
            cmd_done  <= ev_done;
            exec_go   <= ev_exec;
            if (ev_query)
                pwr_code <= query_code;
        end
    end

    AST_EXEC_WITH_SPINDLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_go |-> spin_en); // R10

    AST_SPINDN_FROM_SPIN: assert property (@(posedge clk) disable iff (!rst_n)
        spin_dn |-> ($past(spin_en) && !spin_en)); // R5

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter bit ACCEPT_OLD_CODES = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rst,
    input  logic                cmd_valid,
    input  logic [PM_OPC_W-1:0] cmd_code,
    input  logic                spin_ready,
    input  logic                spin_stopped,
    output logic                spin_en,
    output logic                spin_dn,
    output logic                if_active,
    output logic                busy,
    output logic                cmd_done,
    output logic                exec_go,
    output logic [PM_OPC_W-1:0] pwr_code
);

    cmd_cls_t            cls;
    pm_state_t           nxt_state;
    logic                ev_done;
    logic                ev_exec;
    logic                ev_spindn;
    logic                ev_query;
    logic [PM_OPC_W-1:0] query_code;

    pwr_cmd_decode #(
        .ACCEPT_OLD_CODES(ACCEPT_OLD_CODES)
    ) dec_i (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_cls   (cls)
    );

    pwr_mode_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_rst     (host_rst),
        .cmd_cls      (cls),
        .spin_ready   (spin_ready),
        .spin_stopped (spin_stopped),
        .nxt_state    (nxt_state),
        .ev_done      (ev_done),
        .ev_exec      (ev_exec),
        .ev_spindn    (ev_spindn),
        .ev_query     (ev_query),
        .query_code   (query_code)
    );

    pwr_out_stage out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_state  (nxt_state),
        .ev_done    (ev_done),
        .ev_exec    (ev_exec),
        .ev_spindn  (ev_spindn),
        .ev_query   (ev_query),
        .query_code (query_code),
        .spin_en    (spin_en),
        .spin_dn    (spin_dn),
        .if_active  (if_active),
        .busy       (busy),
        .cmd_done   (cmd_done),
        .exec_go    (exec_go),
        .pwr_code   (pwr_code)
    );

    AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_active && !host_rst) |=> (!cmd_done && !exec_go && !if_active)); // R8

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

    localparam int M_ACT = 0, M_IDLE = 1, M_NOSPIN = 2, M_SDN = 3, M_STBY = 4,
                   M_SLEEP = 5, M_SPINUP = 6;
    localparam int C_IDLE = 1, C_STBY = 2, C_SLEEP = 3, C_QUERY = 4, C_MEDIA = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       spin_ready = 1'b0;
    logic       spin_stopped = 1'b0;
    logic       spin_en, spin_dn, if_active, busy, cmd_done, exec_go;
    logic [7:0] pwr_code;
    logic       n_spin_en, n_spin_dn, n_if_active, n_busy, n_cmd_done, n_exec_go;
    logic [7:0] n_pwr_code;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .spin_ready(spin_ready), .spin_stopped(spin_stopped),
        .spin_en(spin_en), .spin_dn(spin_dn), .if_active(if_active), .busy(busy),
        .cmd_done(cmd_done), .exec_go(exec_go), .pwr_code(pwr_code)
    );

    pwr_mode_ctrl #(.ACCEPT_OLD_CODES(1'b0)) dut_new_i (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .spin_ready(spin_ready), .spin_stopped(spin_stopped),
        .spin_en(n_spin_en), .spin_dn(n_spin_dn), .if_active(n_if_active), .busy(n_busy),
        .cmd_done(n_cmd_done), .exec_go(n_exec_go), .pwr_code(n_pwr_code)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] op);
        cmd_valid = 1'b1;
        cmd_code  = op;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic host_reset();
        host_rst = 1'b1;
        @(negedge clk);
        host_rst = 1'b0;
    endtask

    task automatic go_to(input int m);
        host_reset();
        spin_stopped = 1'b0;
        spin_ready   = 1'b1;
        @(negedge clk);
        case (m)
            M_ACT: send(8'hC8);
            M_SDN: begin spin_ready = 1'b0; send(8'hE0); end
            M_STBY, M_NOSPIN: begin
                spin_ready = 1'b0;
                send(8'hE0);
                spin_stopped = 1'b1;
                @(negedge clk);
                if (m == M_NOSPIN) send(8'hE3);
            end
            M_SLEEP: begin spin_ready = 1'b0; send(8'hE6); spin_stopped = 1'b1; end
            default: ;
        endcase
    endtask

    function automatic int cls_of(input logic [7:0] op);
        case (op)
            8'hE3, 8'h97, 8'hE1, 8'h95: return C_IDLE;
            8'hE2, 8'h96, 8'hE0, 8'h94: return C_STBY;
            8'hE6, 8'h99:               return C_SLEEP;
            8'hE5, 8'h98:               return C_QUERY;
            default:                    return C_MEDIA;
        endcase
    endfunction

    function automatic string tag_of(input int m, input int c);
        if (m == M_SLEEP) return "R8";
        case (c)
            C_IDLE:  return "R4";
            C_STBY:  return (m == M_ACT || m == M_IDLE) ? "R5" : "R6";
            C_SLEEP: return "R8";
            C_QUERY: return (m == M_SDN || m == M_STBY) ? "R7" : "R3";
            default: return "R10";
        endcase
    endfunction

    function automatic int code_of(input int m);
        return (m == M_SDN || m == M_STBY) ? 8'h00 : 8'hFF;
    endfunction

    logic [7:0] ops [16] = '{8'hE3, 8'h97, 8'hE1, 8'h95, 8'hE2, 8'h96, 8'hE0, 8'h94,
                             8'hE6, 8'h99, 8'hE5, 8'h98, 8'hC8, 8'h20, 8'h30, 8'hEF};

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2", "spin_en",   spin_en,   1);
        chk("R2", "busy",      busy,      1);
        chk("R2", "if_active", if_active, 1);
        chk("R2", "cmd_done",  cmd_done,  0);
        chk("R2", "exec_go",   exec_go,   0);
        chk("R2", "spin_dn",   spin_dn,   0);
        chk("R2", "pwr_code",  pwr_code,  8'h00);
        // R11 commands ignored during spin-up
        send(8'hE5);
        chk("R11", "cmd_done while busy", cmd_done, 0);
        spin_ready = 1'b1;
        @(negedge clk);
        chk("R9", "busy after ready", busy, 0);
        chk("R9", "no exec after reset spin-up", exec_go, 0);
        // R12 one-cycle completion pulse
        send(8'hE5);
        chk("R12", "done pulse", cmd_done, 1);
        @(negedge clk);
        chk("R12", "done cleared", cmd_done, 0);

        // R6 skip: spindle already stopped while Idle
        go_to(M_IDLE);
        spin_stopped = 1'b1;
        send(8'hE2);
        chk("R6", "done", cmd_done, 1);
        chk("R6", "no spin_dn", spin_dn, 0);
        chk("R6", "spin_en", spin_en, 0);
        send(8'hE5);
        chk("R6", "code", pwr_code, 8'h00);

        // R5 spin-down completes into Standby
        go_to(M_SDN);
        spin_stopped = 1'b1;
        @(negedge clk);
        send(8'hE2);
        chk("R5", "no second spin_dn", spin_dn, 0);
        send(8'hE3);
        chk("R5", "idle after standby keeps spindle off", spin_en, 0);

        // R1 legacy opcodes disabled in dut_new_i
        go_to(M_IDLE);
        send(8'h99);
        chk("R1", "old sleep accepted", if_active, 0);
        chk("R1", "old code as media exec", n_exec_go, 1);
        chk("R1", "old code no done", n_cmd_done, 0);
        chk("R1", "old code interface", n_if_active, 1);
        send(8'hE6);
        chk("R1", "current sleep", n_if_active, 0);

        // Sweep: every start mode against every opcode class
        for (int m = 0; m < 6; m++) begin
            for (int k = 0; k < 16; k++) begin
                int    c, nx, e_done, e_exec, e_dn;
                bit    spinning;
                string t;
                go_to(m);
                c = cls_of(ops[k]);
                t = tag_of(m, c);
                spinning = (m == M_ACT || m == M_IDLE);
                nx = m; e_done = 0; e_exec = 0; e_dn = 0;
                if (m != M_SLEEP) begin
                    case (c)
                        C_IDLE:  begin e_done = 1; nx = spinning ? M_IDLE : M_NOSPIN; end
                        C_STBY:  begin
                            e_done = 1;
                            if (spinning) begin nx = M_SDN; e_dn = 1; end
                            else if (m == M_SDN) nx = M_SDN;
                            else nx = M_STBY;
                        end
                        C_SLEEP: begin e_done = 1; nx = M_SLEEP; end
                        C_QUERY: e_done = 1;
                        default: begin
                            if (spinning) begin nx = M_ACT; e_exec = 1; end
                            else nx = M_SPINUP;
                        end
                    endcase
                end
                send(ops[k]);
                chk(t, "cmd_done", cmd_done, e_done);
                chk(t, "exec_go",  exec_go,  e_exec);
                chk(t, "spin_dn",  spin_dn,  e_dn);
                chk(t, "if_active", if_active, (nx != M_SLEEP) ? 1 : 0);
                chk(t, "busy", busy, (nx == M_SPINUP) ? 1 : 0);
                chk(t, "spin_en", spin_en,
                    (nx == M_ACT || nx == M_IDLE || nx == M_SPINUP) ? 1 : 0);
                if (c == C_QUERY && m != M_SLEEP)
                    chk(t, "pwr_code", pwr_code, code_of(m));
                if (nx == M_SPINUP) begin
                    send(8'hE5);
                    chk("R11", "query ignored in spin-up", cmd_done, 0);
                    spin_ready = 1'b1;
                    @(negedge clk);
                    chk("R10", "exec after spin_ready", exec_go, 1);
                    nx = M_ACT;
                end
                send(8'hE5);
                if (nx == M_SLEEP) begin
                    chk("R8", "query ignored in sleep", cmd_done, 0);
                    chk("R8", "stays asleep", if_active, 0);
                end else begin
                    chk(t, "follow-up query done", cmd_done, 1);
                    chk(t, "follow-up code", pwr_code, code_of(nx));
                end
            end
        end

        // R9 reset leaves Sleep
        go_to(M_SLEEP);
        host_reset();
        chk("R9", "if_active after reset", if_active, 1);
        chk("R9", "spin_en after reset", spin_en, 1);
        chk("R9", "busy after reset", busy, 1);

        summary();
        $finish;
    end

endmodule